// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block is an ISA-style I/O slave that gives a host access to a small internal bank of configuration registers. It uses two adjacent I/O addresses. The lower address serves as both the key port and the index port. The upper address is the data window onto the register that the index selects. All bus strobes are single-cycle pulses that are synchronous to `clk`. An I/O cycle is decoded only while AEN is low.

After reset the port is locked, and only the unlock byte is recognised. The unlock byte moves the block into configuration mode. While the port is unlocked, the host can:

- select a register by writing its number to the lower address;
- read the selected number back from the lower address;
- read or write the selected register through the upper address.

The lock byte returns the block to run mode.

A strap input is sampled during reset and selects one of two base addresses. Two registers in the bank hold that base address, and the host can rewrite them to move the port at runtime. Another register drives the enable bits of the logical devices, which sit outside this block.

Top module: `kcp_config_port`

## Requirements
- R1: While reset is high and on the first cycle after it, `cfg_mode` is 0, `dev_en` is all zero, and `io_dout_oe` is 0.
- R2: The strap value present on the last reset cycle selects the base address: 0 gives 0x03F0 and 1 gives 0x0370. Register 0x26 reads back the low byte of the current base and register 0x27 reads back the high byte.
- R3: In run mode, writing 0x55 to the base address sets `cfg_mode` from the next cycle.
- R4: In configuration mode, writing 0xAA to the base address clears `cfg_mode` from the next cycle.
- R5: A strobe with `aen` high has no effect on mode, registers or index, and the bus is not driven for it.
- R6: In configuration mode, a write to the base address of any byte other than 0x55 or 0xAA latches that byte as the index. A write of 0x55 while in configuration mode changes nothing. A read of the base address returns the latched index.
- R7: In configuration mode, a read of base+1 returns the register selected by the index. `io_dout_oe` is high and `io_dout` holds the value exactly one cycle after the read strobe. A write to base+1 stores the byte into the selected register.
- R8: In run mode, reads at base or base+1 leave `io_dout_oe` low and `io_dout` at 0. Writes at base+1, and non-key writes at base, change nothing.
- R9: A write to register 0x26 or 0x27 moves the decoded base from the next cycle. The old address then no longer responds.
- R10: Register 0x30 holds the device enable bits. Bit n drives `dev_en[n]`.
- R11: An index at or above the bank size (64) selects nothing. Writes through it are dropped and reads through it return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap | input | 1 | Base-select strap, sampled while reset is high |
| io_addr | input | 16 | I/O address |
| aen | input | 1 | Address enable qualifier; cycles are ignored while high |
| io_rd | input | 1 | Single-cycle read strobe |
| io_wr | input | 1 | Single-cycle write strobe |
| io_din | input | 8 | Write data |
| io_dout | output | 8 | Read data; 0 when not driven |
| io_dout_oe | output | 1 | Read data valid / bus drive enable |
| cfg_mode | output | 1 | High in configuration mode |
| dev_en | output | 8 | Logical device enable bits |
| base_addr | output | 16 | Current decoded base address |

## Verification
The assertions assume that `io_rd` and `io_wr` are never high in the same cycle. They also assume that each strobe is a single-cycle pulse, so a read result always belongs to exactly one strobe. The stimulus drives every bus cycle through one task that raises a single strobe for one clock and then returns it low, and it never overlaps a read with a write. The bench reads a RAM-backed register only after writing it, because that storage has no reset value. The bench's reference model marks every other register read as unknown and leaves its value unchecked.

// File: rtl/kcp_pkg.sv
package kcp_pkg;
  typedef enum logic {MODE_RUN = 1'b0, MODE_CFG = 1'b1} kcp_mode_e;
  typedef enum logic [1:0] {SEL_NONE, SEL_SPEC, SEL_RAM} kcp_rsel_e;

  localparam logic [7:0]  KEY_UNLOCK  = 8'h55;
  localparam logic [7:0]  KEY_LOCK    = 8'hAA;
  localparam logic [7:0]  IDX_BASE_LO = 8'h26;
  localparam logic [7:0]  IDX_BASE_HI = 8'h27;
  localparam logic [15:0] BASE_STRAP0 = 16'h03F0;
  localparam logic [15:0] BASE_STRAP1 = 16'h0370;
endpackage

// File: rtl/kcp_decode.sv
module kcp_decode #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              aen,
  input  logic [ADDR_W-1:0] base,
  output logic              hit_idx,
  output logic              hit_dat
);
  logic [ADDR_W-1:0] base_p1;

  always_comb begin
    base_p1 = base + ADDR_W'(1);
    hit_idx = !aen && (io_addr == base);
    hit_dat = !aen && (io_addr == base_p1);
  end
endmodule

// File: rtl/kcp_key_fsm.sv
module kcp_key_fsm
  import kcp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_key,
  input  logic [7:0] wdata,
  output kcp_mode_e  mode,
  output logic       idx_load
);
  kcp_mode_e mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_RUN;
    end else if (wr_key) begin
      if (mode_q == MODE_RUN && wdata == KEY_UNLOCK) mode_q <= MODE_CFG;
      else if (mode_q == MODE_CFG && wdata == KEY_LOCK) mode_q <= MODE_RUN;
    end
  end

  always_comb begin
    mode     = mode_q;
    idx_load = wr_key && (mode_q == MODE_CFG) &&
               (wdata != KEY_UNLOCK) && (wdata != KEY_LOCK);
  end
endmodule

// File: rtl/kcp_regbank.sv
module kcp_regbank
  import kcp_pkg::*;
#(
  parameter int         ADDR_W    = 16,
  parameter int         NREG      = 64,
  parameter int         NDEV      = 8,
  parameter logic [7:0] DEVEN_IDX = 8'h30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap,
  input  logic              idx_load,
  input  logic              wr_dat,
  input  logic              rd_idx,
  input  logic              rd_dat,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              rdata_oe,
  output logic [ADDR_W-1:0] base,
  output logic [NDEV-1:0]   dev_en
);
  localparam int         AW     = $clog2(NREG);
  localparam logic [8:0] NREG_L = 9'(NREG);

  logic [7:0]      index_q;
  logic [7:0]      base_lo_q, base_hi_q;
  logic [NDEV-1:0] dev_en_q;
  logic [7:0]      mem [NREG];
  logic [7:0]      ram_q;
  logic [7:0]      spec_q;
  kcp_rsel_e       sel_q;
  logic            oe_q;

  logic            in_range, is_special;
  logic [15:0]     base_full;

  always_comb begin
    in_range   = ({1'b0, index_q} < NREG_L);
    is_special = (index_q == IDX_BASE_LO) || (index_q == IDX_BASE_HI) ||
                 (index_q == DEVEN_IDX);
    base_full  = {base_hi_q, base_lo_q};
  end

  // control and special registers
  always_ff @(posedge clk) begin
    if (rst) begin
      index_q   <= '0;
      dev_en_q  <= '0;
      base_lo_q <= strap ? BASE_STRAP1[7:0]  : BASE_STRAP0[7:0];
      base_hi_q <= strap ? BASE_STRAP1[15:8] : BASE_STRAP0[15:8];
    end else begin
      if (idx_load) index_q <= wdata;
      if (wr_dat) begin
        if (index_q == IDX_BASE_LO)    base_lo_q <= wdata;
        else if (index_q == IDX_BASE_HI) base_hi_q <= wdata;
        else if (index_q == DEVEN_IDX) dev_en_q  <= wdata[NDEV-1:0];
      end
    end
  end

  // general storage, block-RAM style: no reset, synchronous read
  always_ff @(posedge clk) begin
    if (wr_dat && in_range && !is_special) mem[index_q[AW-1:0]] <= wdata;
    ram_q <= mem[index_q[AW-1:0]];
  end

  // read pipeline
  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q   <= 1'b0;
      sel_q  <= SEL_NONE;
      spec_q <= '0;
    end else begin
      oe_q  <= rd_idx || rd_dat;
      sel_q <= SEL_NONE;
      if (rd_idx) begin
        sel_q  <= SEL_SPEC;
        spec_q <= index_q;
      end else if (rd_dat) begin
        sel_q <= SEL_SPEC;
        if (index_q == IDX_BASE_LO)    spec_q <= base_lo_q;
        else if (index_q == IDX_BASE_HI) spec_q <= base_hi_q;
        else if (index_q == DEVEN_IDX) spec_q <= 8'(dev_en_q);
        else if (in_range)             sel_q  <= SEL_RAM;
        else                           spec_q <= '0;
      end
    end
  end

  always_comb begin
    rdata_oe = oe_q;
    unique case (sel_q)
      SEL_RAM:  rdata = ram_q;
      SEL_SPEC: rdata = spec_q;
      default:  rdata = '0;
    endcase
    base   = base_full[ADDR_W-1:0];
    dev_en = dev_en_q;
  end
endmodule

// File: rtl/kcp_config_port.sv
module kcp_config_port
  import kcp_pkg::*;
#(
  parameter int         ADDR_W    = 16,
  parameter int         NREG      = 64,
  parameter int         NDEV      = 8,
  parameter logic [7:0] DEVEN_IDX = 8'h30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              aen,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [7:0]        io_din,
  output logic [7:0]        io_dout,
  output logic              io_dout_oe,
  output logic              cfg_mode,
  output logic [NDEV-1:0]   dev_en,
  output logic [ADDR_W-1:0] base_addr
);
  logic      hit_idx, hit_dat;
  logic      wr_key, idx_load;
  logic      wr_dat, rd_idx, rd_dat;
  kcp_mode_e mode;
  logic      unlocked;

  kcp_decode #(.ADDR_W(ADDR_W)) u_dec (
    .io_addr (io_addr),
    .aen     (aen),
    .base    (base_addr),
    .hit_idx (hit_idx),
    .hit_dat (hit_dat)
  );

  kcp_key_fsm u_key (
    .clk      (clk),
    .rst      (rst),
    .wr_key   (wr_key),
    .wdata    (io_din),
    .mode     (mode),
    .idx_load (idx_load)
  );

  always_comb begin
    unlocked = (mode == MODE_CFG);
    wr_key   = io_wr && hit_idx;
    wr_dat   = io_wr && hit_dat && unlocked;
    rd_idx   = io_rd && hit_idx && unlocked;
    rd_dat   = io_rd && hit_dat && unlocked;
    cfg_mode = unlocked;
  end

  kcp_regbank #(
    .ADDR_W    (ADDR_W),
    .NREG      (NREG),
    .NDEV      (NDEV),
    .DEVEN_IDX (DEVEN_IDX)
  ) u_bank (
    .clk      (clk),
    .rst      (rst),
    .strap    (strap),
    .idx_load (idx_load),
    .wr_dat   (wr_dat),
    .rd_idx   (rd_idx),
    .rd_dat   (rd_dat),
    .wdata    (io_din),
    .rdata    (io_dout),
    .rdata_oe (io_dout_oe),
    .base     (base_addr),
    .dev_en   (dev_en)
  );
endmodule

// File: rtl/kcp_config_port_chk.sv
module kcp_config_port_chk #(
  parameter int ADDR_W = 16,
  parameter int NDEV   = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] io_addr,
  input logic              aen,
  input logic              io_rd,
  input logic              io_wr,
  input logic [7:0]        io_din,
  input logic [7:0]        io_dout,
  input logic              io_dout_oe,
  input logic              cfg_mode,
  input logic [NDEV-1:0]   dev_en,
  input logic [ADDR_W-1:0] base_addr
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!cfg_mode && dev_en == '0 && !io_dout_oe));

  p_unlock_r3: assert property (@(posedge clk) disable iff (rst)
    (!cfg_mode && io_wr && !aen && io_addr == base_addr && io_din == 8'h55) |=> cfg_mode);

  p_lock_r4: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode && io_wr && !aen && io_addr == base_addr && io_din == 8'hAA) |=> !cfg_mode);

  p_aen_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    aen |=> ($stable(cfg_mode) && $stable(base_addr) && $stable(dev_en) && !io_dout_oe));

  p_oe_from_read_r7: assert property (@(posedge clk) disable iff (rst)
    io_dout_oe |-> $past(io_rd && !aen));

  p_run_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !cfg_mode |=> (!io_dout_oe && $stable(base_addr) && $stable(dev_en)));

  p_idle_bus_r8: assert property (@(posedge clk) disable iff (rst)
    !io_dout_oe |-> io_dout == 8'h00);

  p_unlock_cause_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_mode) |-> $past(io_wr && io_din == 8'h55));
endmodule

bind kcp_config_port kcp_config_port_chk #(.ADDR_W(ADDR_W), .NDEV(NDEV)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .io_addr    (io_addr),
  .aen        (aen),
  .io_rd      (io_rd),
  .io_wr      (io_wr),
  .io_din     (io_din),
  .io_dout    (io_dout),
  .io_dout_oe (io_dout_oe),
  .cfg_mode   (cfg_mode),
  .dev_en     (dev_en),
  .base_addr  (base_addr)
);

// File: tb/kcp_config_port_tb_top.sv
module kcp_config_port_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1, strap = 1'b0, aen = 1'b0, io_rd = 1'b0, io_wr = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_din = '0;
  logic [7:0]  io_dout;
  logic        io_dout_oe, cfg_mode;
  logic [7:0]  dev_en;
  logic [15:0] base_addr;

  kcp_config_port dut_i (
    .clk(clk), .rst(rst), .strap(strap), .io_addr(io_addr), .aen(aen),
    .io_rd(io_rd), .io_wr(io_wr), .io_din(io_din), .io_dout(io_dout),
    .io_dout_oe(io_dout_oe), .cfg_mode(cfg_mode), .dev_en(dev_en),
    .base_addr(base_addr)
  );

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit    started = 1'b0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  bit         m_mode, m_oe, m_known;
  logic [7:0] m_idx, m_lo, m_hi, m_dev, m_dout;
  logic [7:0] m_mem [int];

  always @(posedge clk) begin : model
    logic [15:0] mb;
    logic        hi, hd;
    started <= 1'b1;
    mb = {m_hi, m_lo};
    hi = !aen && io_addr == mb;
    hd = !aen && io_addr == mb + 16'd1;
    if (rst) begin
      m_mode <= 0; m_idx <= 0; m_dev <= 0; m_oe <= 0; m_known <= 1; m_dout <= 0;
      m_lo <= strap ? 8'h70 : 8'hF0;
      m_hi <= 8'h03;
    end else begin
      m_oe <= 0; m_known <= 1; m_dout <= 0;
      if (io_wr && hi) begin
        if (!m_mode && io_din == 8'h55) m_mode <= 1;
        else if (m_mode && io_din == 8'hAA) m_mode <= 0;
        else if (m_mode && io_din != 8'h55) m_idx <= io_din;
      end
      if (io_wr && hd && m_mode) begin
        if (m_idx == 8'h26) m_lo <= io_din;
        else if (m_idx == 8'h27) m_hi <= io_din;
        else if (m_idx == 8'h30) m_dev <= io_din;
        else if (m_idx < 64) m_mem[int'(m_idx)] = io_din;
      end
      if (io_rd && hi && m_mode) begin
        m_oe <= 1; m_dout <= m_idx;
      end
      if (io_rd && hd && m_mode) begin
        m_oe <= 1;
        if (m_idx == 8'h26) m_dout <= m_lo;
        else if (m_idx == 8'h27) m_dout <= m_hi;
        else if (m_idx == 8'h30) m_dout <= m_dev;
        else if (m_idx >= 64) m_dout <= 8'h00;
        else if (m_mem.exists(int'(m_idx))) m_dout <= m_mem[int'(m_idx)];
        else m_known <= 0;
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      check({cur_req, " mode"}, 32'(cfg_mode), 32'(m_mode));
      check({cur_req, " dev_en"}, 32'(dev_en), 32'(m_dev));
      check({cur_req, " base"}, 32'(base_addr), 32'({m_hi, m_lo}));
      check({cur_req, " oe"}, 32'(io_dout_oe), 32'(m_oe));
      if (m_known) check({cur_req, " dout"}, 32'(io_dout), 32'(m_dout));
    end
  end

  task automatic bus_wr(logic [15:0] a, logic [7:0] d, logic q = 1'b0);
    @(negedge clk);
    io_addr = a; io_din = d; aen = q; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; aen = 1'b0;
  endtask

  task automatic bus_rd(logic [15:0] a, logic q = 1'b0);
    @(negedge clk);
    io_addr = a; aen = q; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0; aen = 1'b0;
  endtask

  task automatic do_reset(logic s);
    @(negedge clk);
    rst = 1'b1; strap = s;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  bit done = 1'b0;

  initial begin
    // R1 / R2: reset state, strap 0
    cur_req = "R1";
    do_reset(1'b0);
    check("R1 mode", 32'(cfg_mode), 0);
    check("R1 dev_en", 32'(dev_en), 0);
    check("R1 oe", 32'(io_dout_oe), 0);
    check("R2 base strap0", 32'(base_addr), 32'h3F0);

    // R8: run mode quiet
    cur_req = "R8";
    bus_rd(16'h3F1);
    check("R8 run read oe", 32'(io_dout_oe), 0);
    check("R8 run read dout", 32'(io_dout), 0);
    bus_wr(16'h3F0, 8'h30);
    bus_wr(16'h3F1, 8'hFF);
    check("R8 run write dev_en", 32'(dev_en), 0);

    // R5: key with aen high ignored
    cur_req = "R5";
    bus_wr(16'h3F0, 8'h55, 1'b1);
    check("R5 aen key", 32'(cfg_mode), 0);

    // R3: unlock
    cur_req = "R3";
    bus_wr(16'h3F0, 8'h55);
    check("R3 unlock", 32'(cfg_mode), 1);
    bus_rd(16'h3F0);
    check("R8 index after run writes", 32'(io_dout), 0);

    // R6: index latch
    cur_req = "R6";
    bus_wr(16'h3F0, 8'h12);
    bus_wr(16'h3F0, 8'h55);
    check("R6 55 keeps mode", 32'(cfg_mode), 1);
    bus_rd(16'h3F0);
    check("R6 index read", 32'(io_dout), 32'h12);
    check("R6 index oe", 32'(io_dout_oe), 1);

    // R7: data window
    cur_req = "R7";
    bus_wr(16'h3F1, 8'hA5);
    bus_wr(16'h3F0, 8'h05);
    bus_wr(16'h3F1, 8'h3C);
    bus_rd(16'h3F1);
    check("R7 reg05", 32'(io_dout), 32'h3C);
    bus_wr(16'h3F0, 8'h12);
    bus_rd(16'h3F1);
    check("R7 reg12", 32'(io_dout), 32'hA5);
    @(negedge clk);
    check("R7 oe one cycle", 32'(io_dout_oe), 0);

    // R5: read with aen high
    cur_req = "R5";
    bus_rd(16'h3F1, 1'b1);
    check("R5 aen read", 32'(io_dout_oe), 0);

    // R10: device enables
    cur_req = "R10";
    bus_wr(16'h3F0, 8'h30);
    bus_wr(16'h3F1, 8'h0F);
    check("R10 dev_en", 32'(dev_en), 32'h0F);
    bus_rd(16'h3F1);
    check("R10 readback", 32'(io_dout), 32'h0F);

    // R11: out-of-range index
    cur_req = "R11";
    bus_wr(16'h3F0, 8'h50);
    bus_wr(16'h3F1, 8'h77);
    bus_rd(16'h3F1);
    check("R11 read zero", 32'(io_dout), 0);
    check("R11 read oe", 32'(io_dout_oe), 1);

    // R2: base readback
    cur_req = "R2";
    bus_wr(16'h3F0, 8'h26);
    bus_rd(16'h3F1);
    check("R2 base lo", 32'(io_dout), 32'hF0);
    bus_wr(16'h3F0, 8'h27);
    bus_rd(16'h3F1);
    check("R2 base hi", 32'(io_dout), 32'h03);

    // R9: relocation
    cur_req = "R9";
    bus_wr(16'h3F1, 8'h02);
    check("R9 base hi moved", 32'(base_addr), 32'h2F0);
    bus_wr(16'h2F0, 8'h26);
    bus_wr(16'h2F1, 8'h60);
    check("R9 base moved", 32'(base_addr), 32'h260);
    bus_rd(16'h2F0);
    check("R9 old silent", 32'(io_dout_oe), 0);
    bus_rd(16'h260);
    check("R9 new index", 32'(io_dout), 32'h26);

    // R4: lock
    cur_req = "R4";
    bus_wr(16'h260, 8'hAA);
    check("R4 lock", 32'(cfg_mode), 0);
    bus_rd(16'h261);
    check("R8 locked read", 32'(io_dout_oe), 0);

    // R1 / R2: reset with strap 1
    cur_req = "R1";
    do_reset(1'b1);
    check("R1 dev_en cleared", 32'(dev_en), 0);
    check("R1 mode cleared", 32'(cfg_mode), 0);
    check("R2 base strap1", 32'(base_addr), 32'h370);
    cur_req = "R2";
    bus_wr(16'h370, 8'h55);
    bus_wr(16'h370, 8'h26);
    bus_rd(16'h371);
    check("R2 strap1 lo", 32'(io_dout), 32'h70);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule